// File: doc/BRIEF.md
# Prescaled Down-Counting Event Timer

This block counts events and signals when a programmed number of them has passed. An event is either a one-cycle internal tick enable or a rising edge on an external input pin. A hidden prescaler divides the events by a programmed divisor DC+1. Each time the prescaler runs out, the 16-bit count register takes one step. A step normally decrements the count. It reloads the count on the step after the count reached zero, which is the overflow. A compare register raises a second event on the step taken while the count matches it.

Software reaches the block through a flat write/read register port. A write to the count while the timer runs is held and lands at the next count step, so it never tears the running count. Two sticky flags record overflow and compare hits, and each one is masked by its own enable to form an interrupt request line. A 3-bit mode field decides how the timer output pin reacts to those events.

Top module: `prescaled_event_timer`

## Requirements
- R1: After reset all registers read zero, both interrupt lines are low and the timer output is low.
- R2: The register map is: address 0 control, 1 count, 2 preload, 3 compare, 4 prescale divisor DC. Control bit 0 enables the timer, bit 1 selects the external source, bit 2 enables the overflow request, bit 3 enables the compare request, and bits 6:4 hold the output mode. With the count loaded with n and the timer enabled, the overflow flag sets on event number (n+1)*(DC+1) and not before.
- R3: On the step taken while the count is zero, the count reloads from the preload register if no count write is pending.
- R4: A count write made while enabled leaves the count unchanged until the next step. That step loads the written value in place of the decrement or the preload reload, and it still raises the overflow when the count was zero.
- R5: A count write made while disabled updates the count at once and cancels any pending write.
- R6: The compare flag sets on the step taken while the count equals the compare register. With the count at n and DC zero, that is event n-compare+1.
- R7: The flags are sticky. The overflow flag reads at control bit 8 and the compare flag at control bit 9. Writing 1 to either bit in a control write clears that flag. Each interrupt line is its flag ANDed with its enable bit.
- R8: Output modes: 0 drives low; 1 gives a one-cycle pulse per overflow; 2 toggles on overflow; 3 gives a one-cycle pulse per compare hit; 4 toggles on compare hit; 5 to 7 hold the present level.
- R9: With bit 1 clear, the tick enable provides the events. With bit 1 set, each rising edge of the external input provides one event, after a two-flop synchronizer, and the tick enable is ignored. While the timer is disabled no event has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the addressed register (combinational) |
| tickEn | input | 1 | Internal event, one per cycle when high |
| extIn | input | 1 | Asynchronous external event input |
| irqOvf | output | 1 | Overflow interrupt request |
| irqCmp | output | 1 | Compare interrupt request |
| timerOut | output | 1 | Timer output pin |

## Verification
The hardest case to reach is a deferred count write that is still pending when the count sits at zero. In that case the written value must win over the preload while the overflow still fires. The bench reaches it by parking the count at zero with the divisor at zero, writing while enabled, and then giving exactly one event. The external source is also hard to drive, because an edge reaches the count only after the synchronizer and edge detector. The bench holds the pin level for several cycles and checks the count before and after each rising edge. The overflow and compare positions are swept over every divisor and start count of a small grid, and the event numbers are compared with the formulas.

// File: rtl/pet_pkg.sv
package pet_pkg;

  localparam logic [2:0] ADDR_CTRL    = 3'd0;
  localparam logic [2:0] ADDR_COUNT   = 3'd1;
  localparam logic [2:0] ADDR_PRELOAD = 3'd2;
  localparam logic [2:0] ADDR_COMPARE = 3'd3;
  localparam logic [2:0] ADDR_DIVISOR = 3'd4;

  localparam int BIT_EN     = 0;
  localparam int BIT_EXTSEL = 1;
  localparam int BIT_OVFIE  = 2;
  localparam int BIT_CMPIE  = 3;
  localparam int BIT_MODE   = 4;
  localparam int BIT_OVFFLG = 8;
  localparam int BIT_CMPFLG = 9;

  typedef struct packed {
    logic       en;
    logic       extSel;
    logic       ovfIe;
    logic       cmpIe;
    logic [2:0] outMode;
  } pet_cfg_t;

  typedef struct packed {
    logic step;
    logic wrCount;
    logic wrPreload;
    logic wrCompare;
    logic clrOvf;
    logic clrCmp;
  } pet_strobes_t;

endpackage

// File: rtl/pet_ctrl.sv
module pet_ctrl
  import pet_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wrData,
  input  logic               tickEn,
  input  logic               extIn,
  output pet_cfg_t           cfg,
  output pet_strobes_t       stb,
  output logic [PRE_W-1:0]   preVal
);

  logic [PRE_W-1:0] preCnt;
  logic [1:0]       extSync;
  logic             extPrev;
  logic             extRise;
  logic             evt;
  logic             wrCtrl;

  assign wrCtrl  = wrEn && (addr == ADDR_CTRL);
  assign extRise = extSync[1] && !extPrev;
  assign evt     = cfg.extSel ? extRise : tickEn;

  always_comb begin
    stb           = '0;
    stb.step      = cfg.en && evt && (preCnt == '0);
    stb.wrCount   = wrEn && (addr == ADDR_COUNT);
    stb.wrPreload = wrEn && (addr == ADDR_PRELOAD);
    stb.wrCompare = wrEn && (addr == ADDR_COMPARE);
    stb.clrOvf    = wrCtrl && wrData[BIT_OVFFLG];
    stb.clrCmp    = wrCtrl && wrData[BIT_CMPFLG];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg     <= '0;
      preVal  <= '0;
      preCnt  <= '0;
      extSync <= '0;
      extPrev <= 1'b0;
    end else begin
      extSync <= {extSync[0], extIn};
      extPrev <= extSync[1];
      if (wrCtrl) begin
        cfg.en      <= wrData[BIT_EN];
        cfg.extSel  <= wrData[BIT_EXTSEL];
        cfg.ovfIe   <= wrData[BIT_OVFIE];
        cfg.cmpIe   <= wrData[BIT_CMPIE];
        cfg.outMode <= wrData[BIT_MODE +: 3];
      end
      if (wrEn && (addr == ADDR_DIVISOR)) preVal <= wrData[PRE_W-1:0];
      if (!cfg.en)      preCnt <= preVal;
      else if (evt)     preCnt <= (preCnt == '0) ? preVal : preCnt - 1'b1;
    end
  end

  // R2: a step restarts the prescaler from the programmed divisor
  assert_prescale_reload_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> (preCnt == $past(preVal)));

  // R9: an external event follows a rising level seen two cycles earlier
  assert_ext_sync_R9: assert property (@(posedge clk) disable iff (!rstN)
    extRise |-> ($past(extIn, 2) && !$past(extIn, 3)));

endmodule

// File: rtl/pet_datapath.sv
module pet_datapath
  import pet_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pet_strobes_t     stb,
  input  logic             enable,
  input  logic [2:0]       outMode,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] compare,
  output logic             ovfFlag,
  output logic             cmpFlag,
  output logic             timerOut
);

  logic [CNT_W-1:0] pendVal;
  logic             pending;
  logic             ovfHit;
  logic             cmpHit;

  assign ovfHit = stb.step && (count == '0);
  assign cmpHit = stb.step && (count == compare);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      preload  <= '0;
      compare  <= '0;
      pendVal  <= '0;
      pending  <= 1'b0;
      ovfFlag  <= 1'b0;
      cmpFlag  <= 1'b0;
      timerOut <= 1'b0;
    end else begin
      if (stb.wrPreload) preload <= wrData;
      if (stb.wrCompare) compare <= wrData;

      if (stb.step) begin
        if (pending)             count <= pendVal;
        else if (count == '0)    count <= preload;
        else                     count <= count - 1'b1;
      end else if (stb.wrCount && !enable) begin
        count <= wrData;
      end

      if (stb.wrCount)     pending <= enable;
      else if (stb.step)   pending <= 1'b0;
      if (stb.wrCount && enable) pendVal <= wrData;

      ovfFlag <= (ovfFlag && !stb.clrOvf) || ovfHit;
      cmpFlag <= (cmpFlag && !stb.clrCmp) || cmpHit;

      case (outMode)
        3'd0:    timerOut <= 1'b0;
        3'd1:    timerOut <= ovfHit;
        3'd2:    if (ovfHit) timerOut <= !timerOut;
        3'd3:    timerOut <= cmpHit;
        3'd4:    if (cmpHit) timerOut <= !timerOut;
        default: timerOut <= timerOut;
      endcase
    end
  end

  // R2: a step at zero count sets the overflow flag
  assert_ovf_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && count == '0) |=> ovfFlag);

  // R3: without a pending write the zero step reloads the preload
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && count == '0 && !pending) |=> (count == $past(preload)));

  // R4: an enabled count write does not disturb the running count
  assert_defer_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCount && enable && !stb.step) |=> (count == $past(count)));

  // R6: a step at the compare value sets the compare flag
  assert_cmp_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && count == compare) |=> cmpFlag);

  // R7: flags stay set until cleared
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !stb.clrOvf) |=> ovfFlag);

endmodule

// File: rtl/prescaled_event_timer.sv
module prescaled_event_timer
  import pet_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic              tickEn,
  input  logic              extIn,
  output logic              irqOvf,
  output logic              irqCmp,
  output logic              timerOut
);

  pet_cfg_t         cfg;
  pet_strobes_t     stb;
  logic [PRE_W-1:0] preVal;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] preload;
  logic [CNT_W-1:0] compare;
  logic             ovfFlag;
  logic             cmpFlag;
  logic [CNT_W-1:0] ctrlWord;

  pet_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .tickEn(tickEn), .extIn(extIn), .cfg(cfg), .stb(stb), .preVal(preVal)
  );

  pet_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .enable(cfg.en), .outMode(cfg.outMode),
    .wrData(wrData), .count(count), .preload(preload), .compare(compare),
    .ovfFlag(ovfFlag), .cmpFlag(cmpFlag), .timerOut(timerOut)
  );

  always_comb begin
    ctrlWord                 = '0;
    ctrlWord[BIT_EN]         = cfg.en;
    ctrlWord[BIT_EXTSEL]     = cfg.extSel;
    ctrlWord[BIT_OVFIE]      = cfg.ovfIe;
    ctrlWord[BIT_CMPIE]      = cfg.cmpIe;
    ctrlWord[BIT_MODE +: 3]  = cfg.outMode;
    ctrlWord[BIT_OVFFLG]     = ovfFlag;
    ctrlWord[BIT_CMPFLG]     = cmpFlag;
  end

  always_comb begin
    case (addr)
      ADDR_CTRL:    rdData = ctrlWord;
      ADDR_COUNT:   rdData = count;
      ADDR_PRELOAD: rdData = preload;
      ADDR_COMPARE: rdData = compare;
      ADDR_DIVISOR: rdData = CNT_W'(preVal);
      default:      rdData = '0;
    endcase
  end

  assign irqOvf = ovfFlag && cfg.ovfIe;
  assign irqCmp = cmpFlag && cfg.cmpIe;

endmodule

// File: tb/test_prescaled_event_timer.sv
`timescale 1ns/1ps
module test_prescaled_event_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        tickEn = 1'b0;
  logic        extIn = 1'b0;
  logic        irqOvf, irqCmp, timerOut;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] A_CTL = 3'd0, A_CNT = 3'd1, A_PRE = 3'd2, A_CMP = 3'd3, A_DIV = 3'd4;

  always #2.5 clk = ~clk;

  prescaled_event_timer i_prescaled_event_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .tickEn(tickEn), .extIn(extIn), .irqOvf(irqOvf), .irqCmp(irqCmp), .timerOut(timerOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic evt();
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 reg", int'(v), 0);
    end
    chk("R1 irq", int'({irqOvf, irqCmp, timerOut}), 0);

    // R2/R3 overflow position sweep and reload from preload
    for (int dc = 0; dc < 4; dc++) begin
      for (int n = 0; n < 5; n++) begin
        wr(A_CTL, 16'h0300);
        wr(A_DIV, 16'(dc));
        wr(A_CNT, 16'(n));
        wr(A_PRE, 16'(10 + n));
        wr(A_CTL, 16'h0005);
        got = 0;
        for (int e = 1; e <= 40 && got == 0; e++) begin
          evt();
          if (irqOvf) got = e;
        end
        chk("R2 overflow event", got, (n + 1) * (dc + 1));
        rd(A_CNT, v); chk("R3 reload", int'(v), 10 + n);
      end
    end

    // R4 deferred write replaces decrement
    wr(A_CTL, 16'h0300); wr(A_DIV, 0); wr(A_CNT, 2); wr(A_CTL, 16'h0001);
    wr(A_CNT, 7);
    rd(A_CNT, v); chk("R4 held", int'(v), 2);
    evt();
    rd(A_CNT, v); chk("R4 applied", int'(v), 7);

    // R4 pending write beats preload at zero, overflow still raised
    wr(A_CTL, 16'h0300); wr(A_PRE, 5); wr(A_CNT, 0); wr(A_CTL, 16'h0005);
    wr(A_CNT, 9);
    rd(A_CNT, v); chk("R4 held zero", int'(v), 0);
    evt();
    rd(A_CNT, v); chk("R4 over preload", int'(v), 9);
    chk("R4 overflow", int'(irqOvf), 1);
    evt();
    rd(A_CNT, v); chk("R4 decrement after", int'(v), 8);

    // R5 disabled write is immediate and cancels pending
    wr(A_CTL, 16'h0301);
    wr(A_CNT, 9);
    wr(A_CTL, 16'h0000);
    wr(A_CNT, 3);
    rd(A_CNT, v); chk("R5 immediate", int'(v), 3);
    wr(A_CTL, 16'h0001);
    evt();
    rd(A_CNT, v); chk("R5 pending cancelled", int'(v), 2);

    // R6 compare position sweep
    for (int c = 0; c < 5; c++) begin
      wr(A_CTL, 16'h0300); wr(A_DIV, 0); wr(A_CNT, 4); wr(A_PRE, 4);
      wr(A_CMP, 16'(c)); wr(A_CTL, 16'h0009);
      got = 0;
      for (int e = 1; e <= 10 && got == 0; e++) begin
        evt();
        if (irqCmp) got = e;
      end
      chk("R6 compare event", got, 5 - c);
    end

    // R7 masking, sticky, write-1-to-clear
    wr(A_CTL, 16'h0001);
    chk("R7 masked irq", int'(irqCmp), 0);
    rd(A_CTL, v); chk("R7 flag sticky", int'(v[9]), 1);
    wr(A_CTL, 16'h0009);
    chk("R7 irq unmasked", int'(irqCmp), 1);
    wr(A_CTL, 16'h0209);
    rd(A_CTL, v); chk("R7 cleared", int'(v[9]), 0);
    chk("R7 irq low", int'(irqCmp), 0);

    // R8 output modes, every step at zero hits overflow and compare
    wr(A_CTL, 16'h0300); wr(A_DIV, 0); wr(A_PRE, 0); wr(A_CNT, 0); wr(A_CMP, 0);
    wr(A_CTL, 16'h0011);
    evt(); chk("R8 ovf pulse high", int'(timerOut), 1);
    @(negedge clk); chk("R8 ovf pulse low", int'(timerOut), 0);
    wr(A_CTL, 16'h0021);
    evt(); chk("R8 ovf toggle 1", int'(timerOut), 1);
    evt(); chk("R8 ovf toggle 2", int'(timerOut), 0);
    evt(); chk("R8 ovf toggle 3", int'(timerOut), 1);
    wr(A_CTL, 16'h0051);
    evt(); chk("R8 hold", int'(timerOut), 1);
    wr(A_CTL, 16'h0001);
    @(negedge clk); chk("R8 off low", int'(timerOut), 0);
    wr(A_CTL, 16'h0041);
    evt(); chk("R8 cmp toggle", int'(timerOut), 1);
    wr(A_CTL, 16'h0031);
    evt(); chk("R8 cmp pulse high", int'(timerOut), 1);
    @(negedge clk); chk("R8 cmp pulse low", int'(timerOut), 0);

    // R9 external source
    wr(A_CTL, 16'h0300); wr(A_DIV, 0); wr(A_PRE, 0); wr(A_CNT, 5); wr(A_CTL, 16'h0003);
    evt();
    rd(A_CNT, v); chk("R9 tick ignored", int'(v), 5);
    @(negedge clk); extIn = 1'b1;
    repeat (4) @(negedge clk);
    rd(A_CNT, v); chk("R9 first edge", int'(v), 4);
    repeat (4) @(negedge clk);
    rd(A_CNT, v); chk("R9 level no event", int'(v), 4);
    extIn = 1'b0;
    repeat (4) @(negedge clk);
    extIn = 1'b1;
    repeat (4) @(negedge clk);
    rd(A_CNT, v); chk("R9 second edge", int'(v), 3);
    extIn = 1'b0;
    wr(A_CTL, 16'h0000);
    evt();
    rd(A_CNT, v); chk("R9 disabled", int'(v), 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule